// File: doc/BRIEF.md
# Soft Mute Ramp with Silence Detector

This block sits in a stereo sample path and runs once per sample strobe. While the mute input is high, it lowers a shared gain by -0.5 dB on every sample, so that the output fades smoothly to silence instead of dropping at once. Once 240 steps (-120 dB) have been taken, both outputs are forced to exactly zero. When mute is released, the gain climbs back at the same rate and comes to rest at exactly unity.

Alongside the ramp, a detector watches the raw input. It raises a flag once both channels have carried zero for a long unbroken run of samples. After reset, the block also waits out a fixed initialization window. During that window its data outputs stay at zero and incoming samples change no internal state.

Samples are 24-bit two's complement. The gain is an unsigned fixed-point value with 30 fraction bits (unity = 2^30). Each output is round-half-up of x·g/2^30, saturated to the 24-bit range.

Top module: `soft_mute_zero`

## Requirements
- R1: While rst_n is low at a clock edge, out_vld, out_l, out_r and zero_flag are all 0 after that edge.
- R2: For the first 1024 clock edges after rst_n goes high, every sample written to the outputs has out_l = out_r = 0. out_vld still follows in_vld during this window.
- R3: out_vld equals in_vld delayed by one clock. out_l and out_r change only on cycles where out_vld is 1.
- R4: At unity gain each output equals its input, including the extremes 0x7FFFFF and 0x800000.
- R5: On each accepted sample with mute = 1, if fewer than 240 steps have been taken, the step count increases and the gain becomes round(g·61870/65536). The sample itself uses the gain in force before the update. Once 240 steps are reached, both outputs are exactly 0.
- R6: On each accepted sample with mute = 0 and a nonzero step count, the count decreases and the gain becomes min(unity, round(g·69419/65536)). When the count reaches 0, the gain is set to exactly unity.
- R7: Each output is floor((x·g + 2^29) / 2^30), clamped to [-8388608, 8388607].
- R8: zero_flag rises with the output of the 1024th consecutive accepted sample in which both in_l and in_r are 0.
- R9: An accepted sample with either channel nonzero clears the run, and zero_flag is 0 with that sample's output.
- R10: Samples strobed during the initialization window do not advance the mute ramp or the zero run. A mute held high throughout the window leaves the first later sample at unity gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Sample strobe, one cycle per sample period |
| in_l | input | 24 | Left input sample, two's complement |
| in_r | input | 24 | Right input sample, two's complement |
| mute | input | 1 | High to ramp toward silence, low to ramp back to unity |
| out_vld | output | 1 | Output sample strobe |
| out_l | output | 24 | Left output sample |
| out_r | output | 24 | Right output sample |
| zero_flag | output | 1 | High after a long run of all-zero input on both channels |

## Verification
The assertions assume that in_vld is a single-cycle strobe and that in_l and in_r hold steady whenever it is sampled. They also assume that mute only has an effect at sample strobes. The stimulus drives every input on the falling edge and raises in_vld for one cycle at most every other cycle, so each sample is stable at the edge that takes it. Mute changes are placed between strobes, including reversals partway through a ramp, so that every gain step lines up with exactly one sample.

// File: rtl/smz_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the soft mute / silence detector.
// Assumes: gain is unsigned fixed point with SMZ_GAIN_FRAC fraction bits.
package smz_pkg;
    localparam int SMZ_DATA_W      = 24;
    localparam int SMZ_GAIN_FRAC   = 30;
    localparam int SMZ_COEF_FRAC   = 16;
    localparam int SMZ_STEP_DN     = 61870;  // 10^(-0.5/20) * 2^16
    localparam int SMZ_STEP_UP     = 69419;  // 10^(+0.5/20) * 2^16
    localparam int SMZ_FLOOR_STEPS = 240;    // 240 * 0.5 dB = 120 dB
    localparam int SMZ_HOLD_CYCLES = 1024;
    localparam int SMZ_ZERO_RUN    = 1024;

    typedef enum logic [1:0] {
        RAMP_STAY = 2'd0,
        RAMP_FALL = 2'd1,
        RAMP_RISE = 2'd2
    } ramp_dir_t;
endpackage

// File: rtl/smz_init_hold.sv
`timescale 1ns/1ps
// Post-reset initialization window: hold is high for HOLD_CYCLES edges
// after rst_n is released, then stays low until the next reset.
module smz_init_hold #(
    parameter int HOLD_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic hold
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES);

    logic [CW-1:0] cnt_q;

    // Count edges since reset release, saturating at the window length.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign hold = (cnt_q != LAST);
endmodule

// File: rtl/smz_gain_ramp.sv
`timescale 1ns/1ps
// Logarithmic gain ramp: one -0.5 dB or +0.5 dB step per accepted sample.
// Assumes adv pulses once per sample period. silent flags the -120 dB floor.
module smz_gain_ramp
    import smz_pkg::*;
#(
    parameter int GAIN_FRAC   = SMZ_GAIN_FRAC,
    parameter int COEF_FRAC   = SMZ_COEF_FRAC,
    parameter int STEP_DN     = SMZ_STEP_DN,
    parameter int STEP_UP     = SMZ_STEP_UP,
    parameter int FLOOR_STEPS = SMZ_FLOOR_STEPS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  logic                 mute,
    output logic [GAIN_FRAC:0]   gain,
    output logic                 silent
);
    localparam int GW = GAIN_FRAC + 1;
    localparam int SW = $clog2(FLOOR_STEPS + 1);
    localparam int PW = GW + COEF_FRAC + 2;
    localparam logic [GW-1:0] UNITY  = GW'(1) << GAIN_FRAC;
    localparam logic [SW-1:0] FLOOR  = SW'(FLOOR_STEPS);
    localparam logic [PW-1:0] HALF_C = PW'(1) << (COEF_FRAC - 1);

    logic [SW-1:0] step_q;
    logic [GW-1:0] gain_q;
    logic [PW-1:0] dn_sh, up_sh;
    logic [GW-1:0] dn_val, up_val;
    ramp_dir_t     dir;

    // Next gain candidates for a falling and a rising step, rounded and capped at unity.
    always_comb begin
        dn_sh  = (PW'(gain_q) * PW'(STEP_DN) + HALF_C) >> COEF_FRAC;
        up_sh  = (PW'(gain_q) * PW'(STEP_UP) + HALF_C) >> COEF_FRAC;
        dn_val = (dn_sh > PW'(UNITY)) ? UNITY : dn_sh[GW-1:0];
        up_val = (up_sh > PW'(UNITY)) ? UNITY : up_sh[GW-1:0];
    end

    // Pick the direction of this sample's step.
    always_comb begin
        if (!adv)                          dir = RAMP_STAY;
        else if (mute && step_q != FLOOR)  dir = RAMP_FALL;
        else if (!mute && step_q != '0)    dir = RAMP_RISE;
        else                               dir = RAMP_STAY;
    end

    // Apply one step per accepted sample; snap to exact unity on the last rising step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
            gain_q <= UNITY;
        end else begin
            case (dir)
                RAMP_FALL: begin
                    step_q <= step_q + 1'b1;
                    gain_q <= dn_val;
                end
                RAMP_RISE: begin
                    step_q <= step_q - 1'b1;
                    gain_q <= (step_q == SW'(1)) ? UNITY : up_val;
                end
                default: ;
            endcase
        end
    end

    assign gain   = gain_q;
    assign silent = (step_q == FLOOR);
endmodule

// File: rtl/smz_scale.sv
`timescale 1ns/1ps
// Combinational sample scaler: y = sat(round_half_up(x * g / 2^GAIN_FRAC)).
// Assumes gain never exceeds unity, but saturates regardless.
module smz_scale #(
    parameter int DATA_W    = 24,
    parameter int GAIN_FRAC = 30
) (
    input  logic [DATA_W-1:0]  x,
    input  logic [GAIN_FRAC:0] gain,
    output logic [DATA_W-1:0]  y
);
    localparam int PW = DATA_W + GAIN_FRAC + 2;
    localparam logic signed [PW-1:0] HALF = PW'(1) << (GAIN_FRAC - 1);
    localparam logic signed [PW-1:0] MAXV = (PW'(1) << (DATA_W - 1)) - PW'(1);
    localparam logic signed [PW-1:0] MINV = -(PW'(1) << (DATA_W - 1));

    logic signed [PW-1:0] xe, ge, shifted;

    // Multiply, round half up, shift back and clamp to the sample range.
    always_comb begin
        xe      = PW'($signed(x));
        ge      = $signed(PW'(gain));
        shifted = (xe * ge + HALF) >>> GAIN_FRAC;
        if (shifted > MAXV)      y = MAXV[DATA_W-1:0];
        else if (shifted < MINV) y = MINV[DATA_W-1:0];
        else                     y = shifted[DATA_W-1:0];
    end
endmodule

// File: rtl/smz_zero_watch.sv
`timescale 1ns/1ps
// Counts consecutive accepted samples that are zero on both channels and
// raises flag on the ZERO_RUN-th; any nonzero sample restarts the run.
module smz_zero_watch #(
    parameter int ZERO_RUN = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic is_zero,
    output logic flag
);
    localparam int CW = $clog2(ZERO_RUN + 1);
    localparam logic [CW-1:0] FULL = CW'(ZERO_RUN);
    localparam logic [CW-1:0] NEAR = CW'(ZERO_RUN - 1);

    logic [CW-1:0] run_q;

    // Track the zero run and the flag together, one update per accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            flag  <= 1'b0;
        end else if (adv) begin
            if (is_zero) begin
                if (run_q != FULL) run_q <= run_q + 1'b1;
                flag <= (run_q >= NEAR);
            end else begin
                run_q <= '0;
                flag  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/soft_mute_zero.sv
`timescale 1ns/1ps
// Stereo soft mute with silence detector and post-reset output hold.
// Assumes in_vld is a one-cycle strobe per sample period; outputs are
// registered one cycle after the strobe. Reset is synchronous, active low.
module soft_mute_zero
    import smz_pkg::*;
#(
    parameter int DATA_W      = SMZ_DATA_W,
    parameter int GAIN_FRAC   = SMZ_GAIN_FRAC,
    parameter int COEF_FRAC   = SMZ_COEF_FRAC,
    parameter int STEP_DN     = SMZ_STEP_DN,
    parameter int STEP_UP     = SMZ_STEP_UP,
    parameter int FLOOR_STEPS = SMZ_FLOOR_STEPS,
    parameter int HOLD_CYCLES = SMZ_HOLD_CYCLES,
    parameter int ZERO_RUN    = SMZ_ZERO_RUN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_l,
    input  logic [DATA_W-1:0] in_r,
    input  logic              mute,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_l,
    output logic [DATA_W-1:0] out_r,
    output logic              zero_flag
);
    localparam int NCH = 2;

    logic                 hold, adv, silent, both_zero;
    logic [GAIN_FRAC:0]   gain;
    logic [DATA_W-1:0]    ch_in  [NCH];
    logic [DATA_W-1:0]    ch_out [NCH];

    assign adv       = in_vld & ~hold;
    assign both_zero = (in_l == '0) && (in_r == '0);
    assign ch_in[0]  = in_l;
    assign ch_in[1]  = in_r;

    smz_init_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk(clk), .rst_n(rst_n), .hold(hold)
    );

    smz_gain_ramp #(
        .GAIN_FRAC(GAIN_FRAC), .COEF_FRAC(COEF_FRAC), .STEP_DN(STEP_DN),
        .STEP_UP(STEP_UP), .FLOOR_STEPS(FLOOR_STEPS)
    ) u_ramp (
        .clk(clk), .rst_n(rst_n), .adv(adv), .mute(mute),
        .gain(gain), .silent(silent)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        smz_scale #(.DATA_W(DATA_W), .GAIN_FRAC(GAIN_FRAC)) u_scale (
            .x(ch_in[c]), .gain(gain), .y(ch_out[c])
        );
    end

    smz_zero_watch #(.ZERO_RUN(ZERO_RUN)) u_zero (
        .clk(clk), .rst_n(rst_n), .adv(adv), .is_zero(both_zero), .flag(zero_flag)
    );

    // Register the scaled samples, forcing zero during the hold window or at the floor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_l   <= '0;
            out_r   <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_l <= (hold || silent) ? '0 : ch_out[0];
                out_r <= (hold || silent) ? '0 : ch_out[1];
            end
        end
    end
endmodule

// File: rtl/smz_checker.sv
`timescale 1ns/1ps
// Port-level properties of soft_mute_zero, attached by bind.
// Assumes in_vld is a single-cycle strobe with stable data.
module smz_checker #(
    parameter int DATA_W      = 24,
    parameter int HOLD_CYCLES = 1024
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_vld,
    input logic [DATA_W-1:0] in_l,
    input logic [DATA_W-1:0] in_r,
    input logic              out_vld,
    input logic [DATA_W-1:0] out_l,
    input logic [DATA_W-1:0] out_r,
    input logic              zero_flag
);
    localparam int CW = $clog2(HOLD_CYCLES + 2);
    localparam logic [CW-1:0] SAT = CW'(HOLD_CYCLES + 1);

    logic [CW-1:0] since_rst;

    // Independent count of edges since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != SAT) since_rst <= since_rst + 1'b1;
    end

    a_r3_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    a_r3_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);
    a_r3_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> ($stable(out_l) && $stable(out_r)));
    a_r2_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && since_rst <= CW'(HOLD_CYCLES)) |-> (out_l == '0 && out_r == '0));
    a_r8_flag_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zero_flag) |-> ($past(in_l) == '0 && $past(in_r) == '0 && $past(in_vld)));
    a_r9_nonzero_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && (in_l != '0 || in_r != '0)) |=> !zero_flag);
endmodule

bind soft_mute_zero smz_checker #(.DATA_W(DATA_W), .HOLD_CYCLES(HOLD_CYCLES)) u_smz_chk (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_l(in_l), .in_r(in_r),
    .out_vld(out_vld), .out_l(out_l), .out_r(out_r), .zero_flag(zero_flag)
);

// File: tb/soft_mute_zero_bench.sv
`timescale 1ns/1ps
module soft_mute_zero_bench;
    localparam longint UNITY = 64'sd1 <<< 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [23:0] in_l = '0, in_r = '0;
    logic        mute = 1'b0;
    logic        out_vld, zero_flag;
    logic [23:0] out_l, out_r;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    soft_mute_zero u_soft_mute_zero (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_l(in_l), .in_r(in_r),
        .mute(mute), .out_vld(out_vld), .out_l(out_l), .out_r(out_r),
        .zero_flag(zero_flag)
    );

    function automatic longint scl(longint x, longint g);
        longint p;
        p = (x * g + (64'sd1 <<< 29)) >>> 30;
        if (p > 8388607)  p = 8388607;
        if (p < -8388608) p = -8388608;
        return p;
    endfunction

    task automatic check(string tag, longint act, longint exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, compared on every clock.
    int     m_hold = 0, m_step = 0, m_run = 0;
    longint m_gain = UNITY;
    longint e_l = 0, e_r = 0;
    bit     e_vld = 0, e_flag = 0;
    initial begin
        forever begin
            @(posedge clk);
            if (!rst_n) begin
                m_hold = 0; m_step = 0; m_run = 0; m_gain = UNITY;
                e_l = 0; e_r = 0; e_vld = 0; e_flag = 0;
            end else begin
                bit hold_now;
                hold_now = (m_hold < 1024);
                e_vld = in_vld;
                if (in_vld) begin
                    if (hold_now || m_step == 240) begin
                        e_l = 0; e_r = 0;
                    end else begin
                        e_l = scl(longint'($signed(in_l)), m_gain);
                        e_r = scl(longint'($signed(in_r)), m_gain);
                    end
                    if (!hold_now) begin
                        if (in_l == 0 && in_r == 0) begin
                            if (m_run < 1024) m_run++;
                            e_flag = (m_run >= 1024);
                        end else begin
                            m_run = 0; e_flag = 0;
                        end
                        if (mute && m_step < 240) begin
                            m_step++;
                            m_gain = (m_gain * 61870 + 32768) >>> 16;
                        end else if (!mute && m_step > 0) begin
                            m_step--;
                            if (m_step == 0) m_gain = UNITY;
                            else begin
                                m_gain = (m_gain * 69419 + 32768) >>> 16;
                                if (m_gain > UNITY) m_gain = UNITY;
                            end
                        end
                    end
                end
                if (hold_now) m_hold++;
            end
            #2;
            if (!done) begin
                check("R3 out_vld", longint'(out_vld), longint'(e_vld));
                check(m_hold < 1024 ? "R2 out_l" : "R7 out_l", longint'($signed(out_l)), e_l);
                check(m_hold < 1024 ? "R2 out_r" : "R7 out_r", longint'($signed(out_r)), e_r);
                check("R8 zero_flag", longint'(zero_flag), longint'(e_flag));
            end
        end
    end

    task automatic send(int l, int r);
        @(negedge clk);
        in_vld = 1'b1; in_l = 24'(l); in_r = 24'(r);
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 out_vld", longint'(out_vld), 0);
        check("R1 out_l", longint'(out_l), 0);
        check("R1 zero_flag", longint'(zero_flag), 0);
        rst_n = 1'b1;

        // Hold window: samples with mute high must not reach the outputs or the ramp (R2, R10).
        mute = 1'b1;
        for (int i = 0; i < 500; i++) send(i * 1000 + 5, -(i * 777) - 3);
        check("R2 hold out_l", longint'($signed(out_l)), 0);
        mute = 1'b0;
        for (int i = 0; i < 20; i++) send(8388607, -8388608);
        check("R4 R10 full scale l", longint'($signed(out_l)), 8388607);
        check("R4 R10 full scale r", longint'($signed(out_r)), -8388608);

        // Fall to the floor (R5).
        mute = 1'b1;
        for (int i = 0; i < 250; i++) send((i % 2) ? 8388607 : -8388608, 4000000);
        check("R5 floor l", longint'($signed(out_l)), 0);
        check("R5 floor r", longint'($signed(out_r)), 0);
        repeat (5) @(negedge clk);

        // Rise back to unity (R6).
        mute = 1'b0;
        for (int i = 0; i < 250; i++) send(3000000 - i * 1000, -1234567);
        check("R6 unity l", longint'($signed(out_l)), 3000000 - 249 * 1000);
        check("R6 unity r", longint'($signed(out_r)), -1234567);

        // Zero run and flag (R8, R9).
        for (int i = 0; i < 1023; i++) send(0, 0);
        check("R8 flag before run", longint'(zero_flag), 0);
        send(0, 0);
        check("R8 flag at run", longint'(zero_flag), 1);
        send(0, 1);
        check("R9 flag cleared r", longint'(zero_flag), 0);
        for (int i = 0; i < 1024; i++) send(0, 0);
        check("R8 flag again", longint'(zero_flag), 1);
        send(-1, 0);
        check("R9 flag cleared l", longint'(zero_flag), 0);

        // Reversal partway through the ramp (R5, R6, R7).
        mute = 1'b1;
        for (int i = 0; i < 12; i++) send(5000000 + i, -7000000);
        mute = 1'b0;
        for (int i = 0; i < 14; i++) send(1, -1);
        check("R6 back to unity", longint'($signed(out_l)), 1);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule